// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a single-data-rate SDRAM. It takes the memory from reset to a programmed, idle state. Once the clock is reported stable, it holds the command bus at no-operation for the power-up settling time. It then closes every bank, runs two refresh cycles and writes the mode register from a set of mode inputs. After that it raises a ready flag and keeps the array alive with evenly spread auto-refresh commands.

All timing comes from nanosecond parameters and the clock period. They are converted to whole cycles by rounding up. The refresh interval is the retention window divided by the row count, rounded down. Commands leave the block on registered chip-select, row-strobe, column-strobe and write-enable lines. The codes on {cs_n,ras_n,cas_n,we_n} are:

| Command | Code |
|---|---|
| inhibit | 1111 |
| no-operation | 0111 |
| precharge | 0010 |
| auto refresh | 0001 |
| mode load | 0000 |

Top module: `sdram_powerup_seq`

## Requirements
- R1: While rst is high, each clock edge leaves cs_n high, cke high and ready low.
- R2: While clk_ok is low and the power-up wait is still running, the bus carries inhibit (1111), and the wait count restarts. Once clk_ok is high, exactly INIT_CYC consecutive no-operation cycles (0111) follow, and then a precharge is issued. INIT_CYC is INIT_WAIT_NS rounded up to whole clocks.
- R3: The precharge (0010) drives addr bit 10 high, every other addr bit low, and ba all zero.
- R4: Exactly two auto refresh commands (0001) lie between the precharge and the mode load (0000). The first follows the precharge after T_RP cycles. The second follows the first after T_RFC cycles. The mode load follows the second after T_RFC cycles. Only no-operation appears in between.
- R5: During the mode load, ba is zero and the address carries the mode word. Bits [2:0] hold the burst length code and bit 3 the burst type (1 = interleaved). Bits [6:4] hold the CAS latency and bit 9 the write burst mode (1 = single access). Bits 8:7, 11:10 and every bit above 11 are zero.
- R6: A cl_sel value of 2 gives latency code 010. Any other value gives code 011.
- R7: Burst length codes 000 to 011 pass through unchanged. Code 111 passes only with sequential type. Every other case is replaced by 011.
- R8: ready rises exactly T_MRD_CYC cycles after the mode load, on a no-operation cycle. Once high, it stays high until reset.
- R9: After ready rises, an auto refresh with zero address and bank is issued every REF_INT cycles. The first one comes REF_INT cycles after ready rises. All other cycles carry no-operation.
- R10: cke stays high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_ok | input | 1 | Memory clock is stable |
| bl_sel | input | 3 | Burst length code |
| bt_ilv | input | 1 | Burst type, 1 = interleaved |
| cl_sel | input | 3 | Requested CAS latency in cycles |
| wb_single | input | 1 | Write burst mode, 1 = single access |
| cke | output | 1 | Clock enable |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| ready | output | 1 | Initialization complete |

## Verification
Suppose the shared delay counter is loaded wrongly, or the state register skips a step. The spacing between the precharge, the two refreshes and the mode load then moves by at least one cycle, or a refresh goes missing. This shows on the command lines within a few dozen cycles of the power-up wait ending. A fault in the mode word shows as a wrong address value in the single mode-load cycle. A fault in the refresh timer shows as a wrong interval at the first periodic refresh, REF_INT cycles after ready rises.

// File: rtl/sdr_init_pkg.sv
package sdr_init_pkg;

  typedef enum logic [3:0] {
    CMD_INH = 4'b1111,
    CMD_NOP = 4'b0111,
    CMD_PRE = 4'b0010,
    CMD_REF = 4'b0001,
    CMD_LMR = 4'b0000
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    S_WAIT,
    S_PRE_GAP,
    S_REF1_GAP,
    S_REF2_GAP,
    S_MRD_GAP,
    S_RUN
  } seq_state_e;

  // Round a nanosecond figure up to whole clock cycles.
  function automatic int ns_to_cyc(input longint ns, input longint clk_ps);
    return int'((ns * 1000 + clk_ps - 1) / clk_ps);
  endfunction

endpackage

// File: rtl/sdr_mode_word.sv
module sdr_mode_word #(
  parameter int ADDR_W = 13
) (
  input  logic [2:0]        bl_sel,
  input  logic              bt_ilv,
  input  logic [2:0]        cl_sel,
  input  logic              wb_single,
  output logic [ADDR_W-1:0] op
);

  logic [2:0] bl_fix;
  logic [2:0] cl_fix;

  always_comb begin
    // Burst length: 1/2/4/8 kept, full page only with sequential type.
    if (bl_sel <= 3'd3)
      bl_fix = bl_sel;
    else if (bl_sel == 3'b111 && !bt_ilv)
      bl_fix = bl_sel;
    else
      bl_fix = 3'b011;
    // Latency: 2 kept, everything else falls back to 3.
    cl_fix = (cl_sel == 3'd2) ? 3'b010 : 3'b011;
  end

  always_comb begin
    op      = '0;
    op[2:0] = bl_fix;
    op[3]   = bt_ilv;
    op[6:4] = cl_fix;
    op[9]   = wb_single;
  end

endmodule

// File: rtl/sdr_interval_timer.sv
module sdr_interval_timer #(
  parameter int PERIOD = 3906
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);

  localparam int CNT_W = $clog2(PERIOD + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !en)
      cnt <= RELOAD;
    else if (cnt == '0)
      cnt <= RELOAD;
    else
      cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
  import sdr_init_pkg::*;
#(
  parameter int CLK_PERIOD_PS     = 4000,
  parameter int INIT_WAIT_NS      = 100000,
  parameter int T_RP_NS           = 20,
  parameter int T_RFC_NS          = 70,
  parameter int T_MRD_CYC         = 2,
  parameter int REFRESH_ROWS      = 4096,
  parameter int REFRESH_WINDOW_US = 64000,
  parameter int ADDR_W            = 13,
  parameter int BA_W              = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_ok,
  input  logic [2:0]        bl_sel,
  input  logic              bt_ilv,
  input  logic [2:0]        cl_sel,
  input  logic              wb_single,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready
);

  localparam int INIT_CYC = ns_to_cyc(INIT_WAIT_NS, CLK_PERIOD_PS);
  localparam int T_RP_CYC = ns_to_cyc(T_RP_NS, CLK_PERIOD_PS);
  localparam int T_RFC_CYC = ns_to_cyc(T_RFC_NS, CLK_PERIOD_PS);
  localparam int REF_INT = int'((longint'(REFRESH_WINDOW_US) * 1000000) /
                                (longint'(REFRESH_ROWS) * CLK_PERIOD_PS));
  localparam int GAP_MAX = (T_RP_CYC > T_RFC_CYC) ?
                           ((T_RP_CYC > T_MRD_CYC) ? T_RP_CYC : T_MRD_CYC) :
                           ((T_RFC_CYC > T_MRD_CYC) ? T_RFC_CYC : T_MRD_CYC);
  localparam int DLY_MAX = (INIT_CYC > GAP_MAX) ? INIT_CYC : GAP_MAX;
  localparam int DLY_W = $clog2(DLY_MAX + 1);

  localparam logic [DLY_W-1:0]  D_INIT = DLY_W'(INIT_CYC);
  localparam logic [DLY_W-1:0]  D_RP   = DLY_W'(T_RP_CYC);
  localparam logic [DLY_W-1:0]  D_RFC  = DLY_W'(T_RFC_CYC);
  localparam logic [DLY_W-1:0]  D_MRD  = DLY_W'(T_MRD_CYC);
  localparam logic [ADDR_W-1:0] A_PRE_ALL = ADDR_W'(1) << 10;

  seq_state_e        st;
  logic [DLY_W-1:0]  dly;
  sdr_cmd_e          cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BA_W-1:0]   ba_q;
  logic              ready_q;
  logic              cke_q;
  logic [ADDR_W-1:0] mode_op;
  logic              ref_tick;
  logic              gap_done;

  sdr_mode_word #(.ADDR_W(ADDR_W)) u_mode (
    .bl_sel    (bl_sel),
    .bt_ilv    (bt_ilv),
    .cl_sel    (cl_sel),
    .wb_single (wb_single),
    .op        (mode_op)
  );

  sdr_interval_timer #(.PERIOD(REF_INT)) u_refi (
    .clk  (clk),
    .rst  (rst),
    .en   (st == S_RUN),
    .tick (ref_tick)
  );

  assign gap_done = (dly <= DLY_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_WAIT;
      dly     <= D_INIT;
      cmd_q   <= CMD_INH;
      addr_q  <= '0;
      ba_q    <= '0;
      ready_q <= 1'b0;
      cke_q   <= 1'b1;
    end else begin
      cke_q  <= 1'b1;
      cmd_q  <= CMD_NOP;
      addr_q <= '0;
      ba_q   <= '0;
      case (st)
        S_WAIT: begin
          if (!clk_ok) begin
            cmd_q <= CMD_INH;
            dly   <= D_INIT;
          end else if (dly == '0) begin
            cmd_q  <= CMD_PRE;
            addr_q <= A_PRE_ALL;
            dly    <= D_RP;
            st     <= S_PRE_GAP;
          end else begin
            dly <= dly - 1'b1;
          end
        end
        S_PRE_GAP: begin
          if (gap_done) begin
            cmd_q <= CMD_REF;
            dly   <= D_RFC;
            st    <= S_REF1_GAP;
          end else begin
            dly <= dly - 1'b1;
          end
        end
        S_REF1_GAP: begin
          if (gap_done) begin
            cmd_q <= CMD_REF;
            dly   <= D_RFC;
            st    <= S_REF2_GAP;
          end else begin
            dly <= dly - 1'b1;
          end
        end
        S_REF2_GAP: begin
          if (gap_done) begin
            cmd_q  <= CMD_LMR;
            addr_q <= mode_op;
            dly    <= D_MRD;
            st     <= S_MRD_GAP;
          end else begin
            dly <= dly - 1'b1;
          end
        end
        S_MRD_GAP: begin
          if (gap_done) begin
            ready_q <= 1'b1;
            st      <= S_RUN;
          end else begin
            dly <= dly - 1'b1;
          end
        end
        S_RUN: begin
          if (ref_tick)
            cmd_q <= CMD_REF;
        end
        default: st <= S_WAIT;
      endcase
    end
  end

  assign cke   = cke_q;
  assign cs_n  = cmd_q[3];
  assign ras_n = cmd_q[2];
  assign cas_n = cmd_q[1];
  assign we_n  = cmd_q[0];
  assign ba    = ba_q;
  assign addr  = addr_q;
  assign ready = ready_q;

  // R3
  pre_all_banks_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> (addr_q[10] && ba_q == '0));

  // R4
  pre_then_nop_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE || cmd_q == CMD_LMR) |=> (cmd_q == CMD_NOP));

  // R4
  lmr_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_LMR) |-> !ready_q);

  // R6
  lmr_cl_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_LMR) |-> (addr_q[6:4] == 3'd2 || addr_q[6:4] == 3'd3));

  // R7
  lmr_bl_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_LMR) |-> (addr_q[2:0] <= 3'd3 || (addr_q[2:0] == 3'd7 && !addr_q[3])));

  // R8
  ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ready_q |=> ready_q);

  // R9
  run_cmds_chk: assert property (@(posedge clk) disable iff (rst)
    ready_q |-> (cmd_q == CMD_NOP || cmd_q == CMD_REF));

endmodule

// File: tb/sdram_powerup_seq_test.sv
`timescale 1ns/1ps
module sdram_powerup_seq_test;

  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;
  // Expected cycle counts, worked out by hand for the parameters below.
  localparam int E_INIT = 1000;  // 4000 ns / 4 ns
  localparam int E_RP   = 5;     // 20 ns / 4 ns
  localparam int E_RFC  = 18;    // 70 ns / 4 ns, rounded up
  localparam int E_MRD  = 2;
  localparam int E_REFI = 250;   // 64 us / 64 rows / 4 ns

  localparam logic [3:0] C_INH = 4'b1111;
  localparam logic [3:0] C_NOP = 4'b0111;
  localparam logic [3:0] C_PRE = 4'b0010;
  localparam logic [3:0] C_REF = 4'b0001;
  localparam logic [3:0] C_LMR = 4'b0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clk_ok = 1'b1;
  logic [2:0] bl_sel = 3'd3;
  logic bt_ilv = 1'b0;
  logic [2:0] cl_sel = 3'd2;
  logic wb_single = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, ready;
  logic [BA_W-1:0] ba;
  logic [ADDR_W-1:0] addr;

  int checks = 0;
  int failures = 0;
  bit cke_bad = 1'b0;

  wire [3:0] cmd = {cs_n, ras_n, cas_n, we_n};

  always #2 clk = ~clk;

  sdram_powerup_seq #(
    .CLK_PERIOD_PS(4000), .INIT_WAIT_NS(4000), .T_RP_NS(20), .T_RFC_NS(70),
    .T_MRD_CYC(2), .REFRESH_ROWS(64), .REFRESH_WINDOW_US(64),
    .ADDR_W(ADDR_W), .BA_W(BA_W)
  ) uut (
    .clk(clk), .rst(rst), .clk_ok(clk_ok), .bl_sel(bl_sel), .bt_ilv(bt_ilv),
    .cl_sel(cl_sel), .wb_single(wb_single), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .ready(ready)
  );

  always @(negedge clk) if (!rst && cke !== 1'b1) cke_bad = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] exp_op(input logic [2:0] bl, input logic bt,
                                               input logic [2:0] cl, input logic wb);
    logic [2:0] b;
    logic [2:0] c;
    b = (bl <= 3'd3) ? bl : ((bl == 3'd7 && !bt) ? 3'd7 : 3'd3);
    c = (cl == 3'd2) ? 3'd2 : 3'd3;
    return {3'b000, wb, 2'b00, c, bt, b};
  endfunction

  task automatic count_nop(output int n, output logic [3:0] c);
    n = 0;
    @(negedge clk);
    while (cmd == C_NOP && n < 20000) begin
      n++;
      @(negedge clk);
    end
    c = cmd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && cke == 1'b1 && ready == 1'b0, "R1 reset state",
        {cs_n, cke, ready}, 3'b110);
    rst = 1'b0;
  endtask

  task automatic run_init(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                          input logic wb, input string tag);
    int n;
    int k;
    logic [3:0] c;
    bl_sel = bl; bt_ilv = bt; cl_sel = cl; wb_single = wb; clk_ok = 1'b1;
    do_reset();
    count_nop(n, c);
    chk(c == C_PRE, "R3 precharge follows wait", c, C_PRE);
    chk(n == E_INIT, "R2 power-up nop count", n, E_INIT);
    chk(addr == 13'h0400 && ba == '0, "R3 precharge all address", addr, 13'h0400);
    count_nop(n, c);
    chk(c == C_REF && n + 1 == E_RP, "R4 first refresh spacing", n + 1, E_RP);
    count_nop(n, c);
    chk(c == C_REF && n + 1 == E_RFC, "R4 second refresh spacing", n + 1, E_RFC);
    count_nop(n, c);
    chk(c == C_LMR && n + 1 == E_RFC, "R4 mode load spacing", n + 1, E_RFC);
    chk(addr == exp_op(bl, bt, cl, wb) && ba == '0, tag, addr, exp_op(bl, bt, cl, wb));
    chk(ready == 1'b0, "R8 not ready at mode load", ready, 0);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!ready && k < 100);
    chk(k == E_MRD && cmd == C_NOP, "R8 ready delay after mode load", k, E_MRD);
    count_nop(n, c);
    chk(c == C_REF && n + 1 == E_REFI, "R9 first periodic refresh", n + 1, E_REFI);
    chk(addr == '0 && ba == '0 && ready, "R9 refresh fields and R8 ready held", addr, 0);
    count_nop(n, c);
    chk(c == C_REF && n + 1 == E_REFI, "R9 second periodic refresh", n + 1, E_REFI);
  endtask

  task automatic clk_ok_drop();
    int n;
    int bad;
    logic [3:0] c;
    bl_sel = 3'd3; bt_ilv = 1'b0; cl_sel = 3'd2; wb_single = 1'b0;
    clk_ok = 1'b0;
    do_reset();
    bad = 0;
    repeat (10) begin
      @(negedge clk);
      if (cmd != C_INH) bad++;
    end
    chk(bad == 0, "R2 inhibit while clock unstable", bad, 0);
    clk_ok = 1'b1;
    repeat (300) @(negedge clk);
    chk(cmd == C_NOP, "R2 nop during wait", cmd, C_NOP);
    clk_ok = 1'b0;
    @(negedge clk);
    chk(cmd == C_INH, "R2 inhibit on clock loss", cmd, C_INH);
    repeat (4) @(negedge clk);
    clk_ok = 1'b1;
    count_nop(n, c);
    chk(c == C_PRE && n == E_INIT, "R2 wait restarts from full count", n, E_INIT);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    run_init(3'd3, 1'b0, 3'd2, 1'b0, "R5 mode word BL8 seq CL2");
    run_init(3'd2, 1'b1, 3'd3, 1'b1, "R5 mode word BL4 ilv CL3 single");
    run_init(3'd5, 1'b0, 3'd5, 1'b0, "R6 R7 clamp reserved BL and CL");
    run_init(3'd7, 1'b1, 3'd0, 1'b0, "R7 full page interleaved clamped");
    run_init(3'd7, 1'b0, 3'd2, 1'b1, "R7 full page sequential kept");
    clk_ok_drop();
    chk(!cke_bad, "R10 cke always high", cke_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule